// File: doc/BRIEF.md
# Multi-Bank Level Interrupt Controller

This block collects level-sensitive interrupt sources in banks of 32 and routes them to three outputs: a normal interrupt, a fast interrupt and an endpoint interrupt. Every bank has three independent enable masks, one for each output. An output is asserted when any source that its mask enables is high in any bank. The sources need no acknowledge. A source stays pending for as long as its input is high.

Software works through a simple register bus. Each bank occupies a 16-byte window. The window holds a read-only view of the raw source levels and the three mask registers. One further register, placed after the last bank window, returns the lowest-numbered source that is pending under the normal mask. Software uses it to service the normal interrupt from the lowest source upward. The number of banks is a parameter and defaults to 2, which gives 64 sources.

Top module: `level_irq_ctrl`

## Requirements
- R1: Source n is bit (n mod 32) of bank (n / 32). Reading byte offset 0x0 of bank b's window, at byte address 16*b, returns the current levels of sources 32*b to 32*b+31, with the lowest source in bit 0.
- R2: Bank b's window holds the normal mask at offset 0x4, the fast mask at offset 0x8 and the endpoint mask at offset 0xC. A mask write stores the write data. Read data appears on the read-data port in the cycle after the read strobe. A mask bit of 1 enables its source and a mask bit of 0 disables it.
- R3: All masks reset to 0. While all masks are 0, irq_o, fiq_o and ep_o stay low, whatever the source levels are.
- R4: A write to a cause offset changes nothing: neither the masks nor the levels that are read back.
- R5: irq_o is high in the cycle after (sources AND normal mask) is nonzero in any bank. It is low in the cycle after that term is zero.
- R6: fiq_o follows (sources AND fast mask) with the same one-cycle timing.
- R7: ep_o follows (sources AND endpoint mask) with the same one-cycle timing.
- R8: Reading byte address 16*NUM_BANKS returns the index word. Bit 31 is 1 when any source is pending under the normal mask. Bits [5:0] give the lowest pending source number (for the default of 2 banks). The word is 0 when nothing is pending.
- R9: Writing one mask register leaves the other masks of the same bank and of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_BANKS*32 | Level interrupt sources |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Normal interrupt |
| fiq_o | output | 1 | Fast interrupt |
| ep_o | output | 1 | Endpoint interrupt |

## Verification
The assertions assume that src_i is already synchronous to clk and that only one write or read strobe is active in a cycle. The bench drives every input one time unit after a rising edge, so the inputs are stable at the edge, and it never raises both strobes together. The mask-stability checks assume the bus is idle or writing only the cause offset. The bench keeps to this by issuing each mask write as a separate transaction.

// File: rtl/intc_pkg.sv
// Shared constants and the register selector type of the level interrupt controller.
// Assumes 32-bit registers and a 16-byte window for each bank.
package intc_pkg;
    localparam int BANK_SRC  = 32;
    localparam int WIN_BYTES = 16;

    typedef enum logic [1:0] {
        SEL_CAUSE = 2'd0,
        SEL_NMASK = 2'd1,
        SEL_FMASK = 2'd2,
        SEL_EMASK = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/intc_bank.sv
// One bank of 32 level sources. It holds the three enable masks, produces the
// masked pending vectors and returns the addressed word for reads.
// Assumes wr_en has already been decoded for this bank.
module intc_bank
    import intc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BANK_SRC-1:0] cause_i,
    input  logic                wr_en,
    input  reg_sel_e            sel,
    input  logic [31:0]         wdata,
    output logic [31:0]         rd_word,
    output logic [BANK_SRC-1:0] pend_n,
    output logic [BANK_SRC-1:0] pend_f,
    output logic [BANK_SRC-1:0] pend_e
);
    logic [BANK_SRC-1:0] nmask, fmask, emask;

    // Mask registers: cleared on reset, loaded by a write to their own offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmask <= '0;
            fmask <= '0;
            emask <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_NMASK: nmask <= wdata;
                SEL_FMASK: fmask <= wdata;
                SEL_EMASK: emask <= wdata;
                default:   ;
            endcase
        end
    end

    // Enabled sources for each of the three outputs.
    always_comb begin
        pend_n = cause_i & nmask;
        pend_f = cause_i & fmask;
        pend_e = cause_i & emask;
    end

    // Read selection within the bank window.
    always_comb begin
        case (sel)
            SEL_CAUSE: rd_word = cause_i;
            SEL_NMASK: rd_word = nmask;
            SEL_FMASK: rd_word = fmask;
            default:   rd_word = emask;
        endcase
    end

    assert_cause_ro_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CAUSE) |=> $stable({nmask, fmask, emask}));

    assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_NMASK) |=> (nmask == $past(wdata)));

    assert_mask_isolate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_FMASK) |=> $stable({nmask, emask}));
endmodule

// File: rtl/intc_lowest.sv
// Finds the lowest set bit of a vector and flags whether any bit is set.
// Purely combinational. The index is 0 when the vector is empty.
module intc_lowest #(
    parameter int W     = 64,
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so that the last hit is the lowest set bit.
    always_comb begin
        idx   = '0;
        valid = |vec;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/level_irq_ctrl.sv
// Level interrupt controller with NUM_BANKS banks of 32 sources. It decodes
// the register bus, combines the pending vectors of all banks into three
// registered outputs and serves the lowest-pending-index register.
// Assumes src_i is synchronous to clk and at most one bus strobe per cycle.
module level_irq_ctrl
    import intc_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    localparam int NSRC   = NUM_BANKS * BANK_SRC,
    localparam int ADDR_W = $clog2((NUM_BANKS + 1) * WIN_BYTES),
    localparam int BSEL_W = ADDR_W - 4,
    localparam int IDX_W  = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o,
    output logic              fiq_o,
    output logic              ep_o
);
    localparam logic [BSEL_W-1:0] IDX_BANK = BSEL_W'(NUM_BANKS);

    logic [BSEL_W-1:0] bank_sel;
    reg_sel_e          reg_sel;
    logic [NSRC-1:0]   pend_n_all, pend_f_all, pend_e_all;
    logic [31:0]       bank_rd [NUM_BANKS];
    logic              idx_valid;
    logic [IDX_W-1:0]  idx;
    logic [31:0]       rd_next;

    // Address split: bank window number and register within the window.
    always_comb begin
        bank_sel = bus_addr_i[ADDR_W-1:4];
        reg_sel  = reg_sel_e'(bus_addr_i[3:2]);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        intc_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .cause_i (src_i[b*BANK_SRC +: BANK_SRC]),
            .wr_en   (bus_wr_i && bank_sel == BSEL_W'(b)),
            .sel     (reg_sel),
            .wdata   (bus_wdata_i),
            .rd_word (bank_rd[b]),
            .pend_n  (pend_n_all[b*BANK_SRC +: BANK_SRC]),
            .pend_f  (pend_f_all[b*BANK_SRC +: BANK_SRC]),
            .pend_e  (pend_e_all[b*BANK_SRC +: BANK_SRC])
        );
    end

    intc_lowest #(.W(NSRC)) u_lowest (
        .vec   (pend_n_all),
        .valid (idx_valid),
        .idx   (idx)
    );

    // Registered outputs: the OR of every enabled source across all banks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
            ep_o  <= 1'b0;
        end else begin
            irq_o <= |pend_n_all;
            fiq_o <= |pend_f_all;
            ep_o  <= |pend_e_all;
        end
    end

    // Read multiplexer across the bank windows and the index register.
    always_comb begin
        rd_next = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_sel == BSEL_W'(b)) rd_next = bank_rd[b];
        end
        if (bank_sel == IDX_BANK && reg_sel == SEL_CAUSE) begin
            rd_next = {idx_valid, {(31 - IDX_W){1'b0}}, idx};
        end
    end

    // Read data register, loaded on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        bus_rdata_o <= '0;
        else if (bus_rd_i) bus_rdata_o <= rd_next;
    end

    assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_n_all) |=> irq_o);
    assert_irq_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pend_n_all) |=> !irq_o);
    assert_fiq_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_f_all) |=> fiq_o);
    assert_ep_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_e_all) |=> ep_o);
    assert_idx_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idx_valid |-> (pend_n_all[idx] &&
            ((pend_n_all & (({{(NSRC-1){1'b0}}, 1'b1} << idx) - 1'b1)) == '0)));
endmodule

// File: tb/sim_level_irq_ctrl.sv
`timescale 1ns/1ps
module sim_level_irq_ctrl;
    localparam int NB = 2;
    localparam int NS = NB * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic          wr = 1'b0, rd = 1'b0;
    logic [5:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq, fiq, ep;

    int  checks = 0, failures = 0;
    bit  done = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    level_irq_ctrl #(.NUM_BANKS(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq), .ep_o(ep));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        tick();
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        rd = 1'b1; addr = a;
        tick();
        rd = 1'b0;
        d = rdata;
    endtask

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic logic [31:0] exp_index(input logic [NS-1:0] v);
        logic [31:0] w = '0;
        for (int i = NS - 1; i >= 0; i--) if (v[i]) w = 32'h8000_0000 | 32'(i);
        return w;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [NS-1:0] nm, fm, em;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R3: reset state
        check("R3 irq reset", {31'd0, irq}, 0);
        check("R3 fiq reset", {31'd0, fiq}, 0);
        check("R3 ep reset", {31'd0, ep}, 0);
        for (int b = 0; b < NB; b++)
            for (int k = 1; k < 4; k++) begin
                bus_read(6'(b*16 + k*4), r);
                check("R3 mask reset", r, 0);
            end

        // R3: all sources high with all masks zero keeps the outputs low
        src = '1;
        tick(); tick();
        check("R3 irq quiet", {31'd0, irq}, 0);
        check("R3 fiq quiet", {31'd0, fiq}, 0);
        check("R3 ep quiet", {31'd0, ep}, 0);
        bus_read(6'(NB*16), r);
        check("R8 empty index", r, 0);

        // R4: cause writes are ignored
        src = '0;
        bus_write(6'h00, 32'hFFFF_FFFF);
        bus_write(6'h10, 32'hA5A5_A5A5);
        bus_read(6'h00, r);  check("R4 cause0 unchanged", r, 0);
        bus_read(6'h10, r);  check("R4 cause1 unchanged", r, 0);
        for (int b = 0; b < NB; b++)
            for (int k = 1; k < 4; k++) begin
                bus_read(6'(b*16 + k*4), r);
                check("R4 masks untouched", r, 0);
            end

        // R2, R9: distinct pattern in every mask register, read back all
        for (int b = 0; b < NB; b++)
            for (int k = 1; k < 4; k++)
                bus_write(6'(b*16 + k*4), 32'h1111_1111 * 32'(b*3 + k));
        for (int b = 0; b < NB; b++)
            for (int k = 1; k < 4; k++) begin
                bus_read(6'(b*16 + k*4), r);
                check("R2 R9 mask readback", r, 32'h1111_1111 * 32'(b*3 + k));
            end

        // R1, R5-R8: sweep each single source with all masks enabled
        for (int b = 0; b < NB; b++)
            for (int k = 1; k < 4; k++) bus_write(6'(b*16 + k*4), 32'hFFFF_FFFF);
        for (int n = 0; n < NS; n++) begin
            src = '0;
            src[n] = 1'b1;
            check("R5 irq not yet", {31'd0, irq}, 0);
            tick();
            check("R5 irq one cycle", {31'd0, irq}, 1);
            check("R6 fiq one cycle", {31'd0, fiq}, 1);
            check("R7 ep one cycle", {31'd0, ep}, 1);
            bus_read(6'((n / 32) * 16), r);
            check("R1 cause bit", r, 32'd1 << (n % 32));
            bus_read(6'(NB*16), r);
            check("R8 single index", r, 32'h8000_0000 | 32'(n));
            src = '0;
            tick();
            check("R5 irq falls", {31'd0, irq}, 0);
        end

        // R5-R9: random sources and masks, expected values computed here
        for (int it = 0; it < 60; it++) begin
            nm = {next_rand() & next_rand(), next_rand() & next_rand()};
            fm = {next_rand() & next_rand(), next_rand() & next_rand()};
            em = {next_rand() & next_rand(), next_rand() & next_rand()};
            if (it % 7 == 0) nm = '0;
            for (int b = 0; b < NB; b++) begin
                bus_write(6'(b*16 + 4),  nm[b*32 +: 32]);
                bus_write(6'(b*16 + 8),  fm[b*32 +: 32]);
                bus_write(6'(b*16 + 12), em[b*32 +: 32]);
            end
            src = {next_rand() & next_rand(), next_rand() & next_rand()};
            tick();
            check("R5 irq random", {31'd0, irq}, {31'd0, |(src & nm)});
            check("R6 fiq random", {31'd0, fiq}, {31'd0, |(src & fm)});
            check("R7 ep random", {31'd0, ep}, {31'd0, |(src & em)});
            bus_read(6'(NB*16), r);
            check("R8 lowest index", r, exp_index(src & nm));
            bus_read(6'h18, r);
            check("R9 bank1 fast mask", r, fm[63:32]);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule